// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It has two components. The first is a table of 2-bit counters indexed by the branch address, and it suits branches that lean strongly one way. The second is a table of 2-bit counters indexed by a register holding the outcomes of recent branches, and it suits branches whose outcome depends on what earlier branches did. A third table of 2-bit counters, the chooser, is also indexed by the branch address. For each branch it decides which component's answer becomes the final prediction.

A front-end stage drives an address on the lookup side and reads back four things on the same cycle: the final prediction, the answer of each component, and the chooser's pick. It also reads back the history value used for the lookup. It keeps these values with the branch. When the branch resolves, the pipeline presents the address, the real outcome and the kept values on the update side. One clock edge then trains every table and shifts the outcome into the history.

Every counter is a four-state machine:

| Code | State | Meaning in a component | Meaning in the chooser |
|---|---|---|---|
| 00 | CTR_SNT | strongly not taken | strongly prefer the address table |
| 01 | CTR_WNT | weakly not taken | weakly prefer the address table |
| 10 | CTR_WT | weakly taken | weakly prefer the history table |
| 11 | CTR_ST | strongly taken | strongly prefer the history table |

Counter transitions:

- On "up", the counter moves SNT→WNT→WT→ST, and ST stays ST.
- On "down", the counter moves ST→WT→WNT→SNT, and SNT stays SNT.
- If the counter is not written, it stays in its state.

Top module: `tourney_bp`

## Requirements
- R1: While `rst_n` is low, every counter in the address table, the history table and the chooser goes to code 01, and the history register clears to zero. The first lookup after reset therefore returns 0 on all three prediction outputs, 0 on `lk_use_glb`, and 0 on `lk_hist`.
- R2: The address table is indexed by address bits [7:2] (BIM_IDX_W=6). Bits [1:0] and the bits above bit 7 do not take part. A component predicts taken when bit 1 of its counter is set.
- R3: A trained counter steps one state up on a taken outcome and one state down on a not-taken outcome. It saturates at 11 and at 00.
- R4: The history table is read at the current history value, which is driven on `lk_hist`. Each update shifts the outcome into bit 0 of the history, moves every other bit one place up, and drops bit GH_W-1.
- R5: The history table is trained at the entry named by `up_hist`, which is the value captured at lookup. It is not trained at the entry named by the current history.
- R6: The chooser is indexed by address bits [6:2] (META_IDX_W=5). A chooser value of 10 or 11 selects the history table, and 00 or 01 selects the address table. `lk_taken` equals the selected component's prediction.
- R7: The chooser entry changes only when `up_bim_taken` differs from `up_glb_taken`. It then steps toward the component whose prediction matched `up_taken`: up toward the history table, down toward the address table. It saturates at both ends.
- R8: Both components are trained with the outcome on every update, whichever one the chooser selected.
- R9: When `up_valid` is low, no counter and no history bit changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | active-low synchronous reset |
| lk_pc | input | PC_W | address of the branch being looked up |
| lk_taken | output | 1 | final direction prediction |
| lk_bim_taken | output | 1 | address-table prediction |
| lk_glb_taken | output | 1 | history-table prediction |
| lk_use_glb | output | 1 | chooser picked the history table |
| lk_hist | output | GH_W | history value used for this lookup |
| up_valid | input | 1 | apply a training update this cycle |
| up_pc | input | PC_W | address of the resolved branch |
| up_taken | input | 1 | resolved outcome |
| up_bim_taken | input | 1 | address-table prediction captured at lookup |
| up_glb_taken | input | 1 | history-table prediction captured at lookup |
| up_hist | input | GH_W | history value captured at lookup |

## Verification
The bench drives one branch into saturation and then breaks its pattern once. A counter that wraps or skips a state would flip the prediction too early. It sends updates whose captured history differs from the live register, which exposes a design that trains the live history entry instead of the captured one. It drives two addresses that differ only above the index bits, and a full set of update inputs with `up_valid` low. A design that decodes too many address bits, or that lets stray updates through, would then return a wrong prediction. Runs in which both components agree must leave the chooser alone; a design that trains the chooser on every update would drift toward one component and change the final output.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    // 2-bit saturating counter states
    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_t;

    function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
        ctr_t nxt;
        unique case (cur)
            CTR_SNT: nxt = up ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = up ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = up ? CTR_ST  : CTR_WNT;
            CTR_ST:  nxt = up ? CTR_ST  : CTR_WT;
            default: nxt = CTR_WNT;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table
    import tbp_pkg::*;
#(
    parameter int   IDX_W   = 6,
    parameter ctr_t RST_VAL = CTR_WNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_val,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0][1:0] cnt_q;
    ctr_t                  wr_cur;
    ctr_t                  wr_nxt;

    // next-state selection for the addressed entry
    always_comb begin
        wr_cur = ctr_t'(cnt_q[wr_idx]);
        wr_nxt = ctr_step(wr_cur, wr_up);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cnt_q[i] <= RST_VAL;
        end else if (wr_en) begin
            cnt_q[wr_idx] <= wr_nxt;
        end
    end

    // output
    always_comb rd_val = ctr_t'(cnt_q[rd_idx]);

    // R3
    ctr_sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up && cnt_q[wr_idx] == 2'b11) |=> cnt_q[$past(wr_idx)] == 2'b11);
    // R3
    ctr_sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_up && cnt_q[wr_idx] == 2'b00) |=> cnt_q[$past(wr_idx)] == 2'b00);
    // R3
    ctr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up && cnt_q[wr_idx] != 2'b11)
        |=> cnt_q[$past(wr_idx)] == $past(cnt_q[wr_idx]) + 2'd1);
    // R9 R7
    ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cnt_q));

endmodule

// File: rtl/tbp_ghist.sv
module tbp_ghist #(
    parameter int GH_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            bit_in,
    output logic [GH_W-1:0] hist
);
    logic [GH_W-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[GH_W-2:0], bit_in};
    end

    always_comb hist = hist_q;

    // R4
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (hist[0] == $past(bit_in)) && (hist[GH_W-1:1] == $past(hist[GH_W-2:0])));
    // R9
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist));

endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
    import tbp_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int BIM_IDX_W  = 6,
    parameter int GH_W       = 6,
    parameter int META_IDX_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    output logic            lk_bim_taken,
    output logic            lk_glb_taken,
    output logic            lk_use_glb,
    output logic [GH_W-1:0] lk_hist,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken,
    input  logic            up_bim_taken,
    input  logic            up_glb_taken,
    input  logic [GH_W-1:0] up_hist
);
    localparam int INSTR_LSB = 2;

    ctr_t            bim_rd;
    ctr_t            glb_rd;
    ctr_t            meta_rd;
    logic [GH_W-1:0] ghist;
    logic            meta_wr;
    logic            meta_up;

    // R7: chooser trains only on disagreement, toward the correct side
    always_comb begin
        meta_wr = up_valid && (up_bim_taken != up_glb_taken);
        meta_up = (up_glb_taken == up_taken);
    end

    // R2 R8: address-indexed component
    tbp_ctr_table #(.IDX_W(BIM_IDX_W), .RST_VAL(CTR_WNT)) u_bim (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lk_pc[INSTR_LSB +: BIM_IDX_W]),
        .rd_val (bim_rd),
        .wr_en  (up_valid),
        .wr_idx (up_pc[INSTR_LSB +: BIM_IDX_W]),
        .wr_up  (up_taken)
    );

    // R4 R5 R8: history-indexed component
    tbp_ctr_table #(.IDX_W(GH_W), .RST_VAL(CTR_WNT)) u_glb (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (ghist),
        .rd_val (glb_rd),
        .wr_en  (up_valid),
        .wr_idx (up_hist),
        .wr_up  (up_taken)
    );

    // R6 R7: chooser
    tbp_ctr_table #(.IDX_W(META_IDX_W), .RST_VAL(CTR_WNT)) u_meta (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lk_pc[INSTR_LSB +: META_IDX_W]),
        .rd_val (meta_rd),
        .wr_en  (meta_wr),
        .wr_idx (up_pc[INSTR_LSB +: META_IDX_W]),
        .wr_up  (meta_up)
    );

    tbp_ghist #(.GH_W(GH_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (up_valid),
        .bit_in   (up_taken),
        .hist     (ghist)
    );

    // outputs
    always_comb begin
        lk_bim_taken = bim_rd[1];
        lk_glb_taken = glb_rd[1];
        lk_use_glb   = meta_rd[1];
        lk_taken     = lk_use_glb ? lk_glb_taken : lk_bim_taken;
        lk_hist      = ghist;
    end

    logic unused_bits;
    assign unused_bits = ^{lk_pc, up_pc, bim_rd[0], glb_rd[0], meta_rd[0]};

    // R6
    agree_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_bim_taken == lk_glb_taken) |-> (lk_taken == lk_bim_taken));
    // R4
    hist_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> lk_hist[0] == $past(up_taken));

endmodule

// File: tb/sim_tourney_bp.sv
module sim_tourney_bp;
    localparam int PC_W = 32;
    localparam int BIM_IDX_W = 6;
    localparam int GH_W = 6;
    localparam int META_IDX_W = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            lk_taken, lk_bim_taken, lk_glb_taken, lk_use_glb;
    logic [GH_W-1:0] lk_hist;
    logic            up_valid = 1'b0;
    logic [PC_W-1:0] up_pc = '0;
    logic            up_taken = 1'b0;
    logic            up_bim_taken = 1'b0;
    logic            up_glb_taken = 1'b0;
    logic [GH_W-1:0] up_hist = '0;

    always #5 clk = ~clk;

    tourney_bp #(.PC_W(PC_W), .BIM_IDX_W(BIM_IDX_W), .GH_W(GH_W), .META_IDX_W(META_IDX_W)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .lk_bim_taken(lk_bim_taken), .lk_glb_taken(lk_glb_taken),
        .lk_use_glb(lk_use_glb), .lk_hist(lk_hist), .up_valid(up_valid),
        .up_pc(up_pc), .up_taken(up_taken), .up_bim_taken(up_bim_taken),
        .up_glb_taken(up_glb_taken), .up_hist(up_hist)
    );

    typedef struct {
        bit        taken;
        bit        bim;
        bit        glb;
        bit        sel;
        bit [5:0]  hist;
        int        req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;

    // behavioural model built from the requirements
    int bim_m[64];
    int glb_m[64];
    int cho_m[32];
    bit [5:0] ghr_m;

    function automatic int sat(input int v, input bit up);
        if (up) return (v == 3) ? 3 : v + 1;
        return (v == 0) ? 0 : v - 1;
    endfunction

    task automatic step(input logic [31:0] pc, input bit do_up, input logic [31:0] upc,
                        input bit outc, input bit own_hist, input bit [5:0] hist_ovr,
                        input int req);
        exp_t e;
        bit ub, ug;
        bit [5:0] uh;
        @(posedge clk); #1;
        e.bim   = bim_m[pc[7:2]] >= 2;
        e.glb   = glb_m[ghr_m] >= 2;
        e.sel   = cho_m[pc[6:2]] >= 2;
        e.taken = e.sel ? e.glb : e.bim;
        e.hist  = ghr_m;
        e.req   = req;
        exp_q.push_back(e);
        lk_pc = pc;
        uh = own_hist ? ghr_m : hist_ovr;
        ub = bim_m[upc[7:2]] >= 2;
        ug = glb_m[uh] >= 2;
        up_valid     = do_up;
        up_pc        = upc;
        up_taken     = outc;
        up_bim_taken = do_up ? ub : 1'b1;
        up_glb_taken = do_up ? ug : 1'b0;
        up_hist      = uh;
        if (do_up) begin
            bim_m[upc[7:2]] = sat(bim_m[upc[7:2]], outc);
            glb_m[uh]       = sat(glb_m[uh], outc);
            if (ub != ug) cho_m[upc[6:2]] = sat(cho_m[upc[6:2]], ug == outc);
            ghr_m = {ghr_m[4:0], outc};
        end
    endtask

    task automatic branch(input logic [31:0] pc, input bit outc, input int req);
        step(pc, 1'b1, pc, outc, 1'b1, 6'd0, req);
    endtask

    task automatic probe(input logic [31:0] pc, input int req);
        step(pc, 1'b0, 32'hFFFF_FFFC, 1'b1, 1'b0, 6'h3F, req);
    endtask

    task automatic cmp(input int req, input string what, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // monitor: compares one queued item per cycle, away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            cmp(e.req, "taken", lk_taken, e.taken);
            cmp(e.req, "bim",   lk_bim_taken, e.bim);
            cmp(e.req, "glb",   lk_glb_taken, e.glb);
            cmp(e.req, "sel",   lk_use_glb, e.sel);
            cmp(e.req, "hist",  lk_hist, e.hist);
        end
    end

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL R0 watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin bim_m[i] = 1; glb_m[i] = 1; end
        for (int i = 0; i < 32; i++) cho_m[i] = 1;
        ghr_m = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state, several addresses
        probe(32'h0000_1000, 1);
        probe(32'h0000_10FC, 1);
        probe(32'h1234_5678, 1);
        // R2 R3: biased taken branch learns, saturates, survives one miss
        for (int i = 0; i < 5; i++) branch(32'h0000_2008, 1'b1, 3);
        branch(32'h0000_2008, 1'b0, 3);
        probe(32'h0000_2008, 3);
        for (int i = 0; i < 4; i++) branch(32'h0000_2008, 1'b0, 3);
        probe(32'h0000_2008, 3);
        // R2: alias above index bits and in the low two bits
        branch(32'h0000_3010, 1'b1, 2);
        branch(32'h0000_3010, 1'b1, 2);
        probe(32'h0FF0_3113, 2);
        probe(32'h0000_3011, 2);
        // R9: a full update with valid low changes nothing
        step(32'h0000_3010, 1'b0, 32'h0000_3010, 1'b0, 1'b0, 6'h15, 9);
        step(32'h0000_3010, 1'b0, 32'h0000_3010, 1'b0, 1'b0, 6'h15, 9);
        probe(32'h0000_3010, 9);
        // R4 R6 R7 R8: pattern branch where history wins the chooser
        for (int k = 0; k < 12; k++) begin
            branch(32'h0000_4020, 1'b1, 7);
            branch(32'h0000_4020, 1'b1, 7);
            branch(32'h0000_4020, 1'b0, 4);
        end
        probe(32'h0000_4020, 6);
        // R7: agreeing runs leave the chooser alone
        for (int i = 0; i < 6; i++) branch(32'h0000_5040, 1'b0, 7);
        probe(32'h0000_5040, 7);
        // R5: train at a captured history unlike the live one
        for (int i = 0; i < 3; i++) step(32'h0000_6000, 1'b1, 32'h0000_6000, 1'b1, 1'b0, 6'h2A, 5);
        for (int i = 0; i < 6; i++) branch(32'h0000_7000, (i % 2) == 0, 5);
        probe(32'h0000_6000, 5);
        probe(32'h0000_7000, 8);
        repeat (3) @(posedge clk);
        #1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule